// File: doc/BRIEF.md
# Code Histogram Coverage Checker

This block gathers the output codes of a data converter under test into a per-code occurrence histogram and then judges whether the capture gave enough samples for histogram-based linearity analysis. A `start` pulse latches the run settings, zeroes every bin one per cycle, and then counts strobed codes until the programmed number of samples has been accepted. After that it walks the bins in ascending order against two minimum-count floors. One floor applies to all bins. A higher floor applies to a programmable code window where finer resolution is wanted, such as the centre of the range. The block reports the first bin that falls short.

Each strobed code costs a read-modify-write of its bin. A forwarding register holds the value just written, so strobes that arrive on consecutive cycles for the same code are each counted. The lowest and highest codes collect overrange samples, so they are exempt from the global floor. They are still held to the window floor when they lie inside the window. A separate read port gives access to any bin's count for later processing.

Top module: `code_hist_cov`

## Requirements
- R1: After reset, `done` and `pass` are low and `fail_idx` and `fail_cnt` are zero.
- R2: A `start` pulse in the idle or done state sets every bin to zero before the next capture, so counts from an earlier run never carry over.
- R3: Each accepted strobe adds exactly one to the bin of its code, including strobes for the same code on consecutive cycles.
- R4: Capture accepts exactly `sample_total` strobes (latched at `start`, zero allowed) and ignores any strobe that arrives after that count is reached.
- R5: A strobe that arrives when no capture is in progress leaves every bin unchanged.
- R6: A bin count stops at 2^CNT_W-1 and never wraps.
- R7: A bin whose code lies in the inclusive window [`win_lo`, `win_hi`] fails when its count is below `floor_win`. This also applies to codes 0 and 2^CODE_BITS-1.
- R8: A bin outside the window fails when its count is below `floor_all`. Codes 0 and 2^CODE_BITS-1 outside the window never fail.
- R9: The scan runs from code 0 upward and stops at the first failing bin. It then shows `done` with `pass` low, `fail_idx` set to that code and `fail_cnt` set to its count.
- R10: When no bin fails, the scan shows `done` with `pass` high and `fail_idx` and `fail_cnt` at zero.
- R11: `done` stays high until the next `start`, and falls in the cycle after `start` is sampled.
- R12: `rd_data` returns the count of bin `rd_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run: latch settings, clear bins, capture |
| adc_valid | input | 1 | Code strobe |
| adc_code | input | CODE_BITS | Converter output code |
| sample_total | input | TOT_W | Number of strobes to accept |
| win_lo | input | CODE_BITS | Lowest code of the high-floor window |
| win_hi | input | CODE_BITS | Highest code of the high-floor window |
| floor_all | input | CNT_W | Minimum count for bins outside the window |
| floor_win | input | CNT_W | Minimum count for bins inside the window |
| done | output | 1 | Scan finished, result valid |
| pass | output | 1 | All bins met their floors |
| fail_idx | output | CODE_BITS | First failing code |
| fail_cnt | output | CNT_W | Count held by the first failing bin |
| rd_addr | input | CODE_BITS | Histogram read address |
| rd_data | output | CNT_W | Histogram count, one cycle after address |

## Verification
The hardest case to reach is the update hazard: a bin's read issued in the same cycle as the write of the previous strobe to that same bin. This only happens when identical codes arrive on back-to-back cycles. The stimulus produces it with a pattern that repeats each code four times in a row at full strobe rate, and then repeats the pattern with idle gaps. Both runs must give the same bin counts. Saturation is reached on a narrow counter width by sending one code more times than the counter can hold. The end-bin exemption is separated from the window rule by placing the window both away from and over the end codes.

// File: rtl/hist_pkg.sv
package hist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_CAPTURE,
        ST_SCAN,
        ST_DONE
    } hist_state_e;

endpackage

// File: rtl/hist_mem.sv
module hist_mem #(
    parameter int AW = 12,
    parameter int DW = 17
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        ra_data <= store[ra_addr];
        rb_data <= store[rb_addr];
    end

endmodule

// File: rtl/hist_bin_eval.sv
module hist_bin_eval #(
    parameter int CODE_BITS   = 12,
    parameter int CNT_W       = 17,
    parameter bit EXEMPT_ENDS = 1'b1
) (
    input  logic [CODE_BITS-1:0] idx,
    input  logic [CNT_W-1:0]     cnt,
    input  logic [CODE_BITS-1:0] lo,
    input  logic [CODE_BITS-1:0] hi,
    input  logic [CNT_W-1:0]     fa,
    input  logic [CNT_W-1:0]     fw,
    output logic                 fail
);
    logic in_win;
    logic is_end;

    generate
        if (EXEMPT_ENDS) begin : g_exempt
            assign is_end = (idx == '0) || (idx == '1);
        end else begin : g_no_exempt
            assign is_end = 1'b0;
        end
    endgenerate

    always_comb begin
        in_win = (idx >= lo) && (idx <= hi);
        if (in_win) begin
            fail = (cnt < fw);
        end else begin
            fail = !is_end && (cnt < fa);
        end
    end

endmodule

// File: rtl/code_hist_cov.sv
module code_hist_cov
    import hist_pkg::*;
#(
    parameter int CODE_BITS   = 12,
    parameter int CNT_W       = 17,
    parameter int TOT_W       = 17,
    parameter bit EXEMPT_ENDS = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 adc_valid,
    input  logic [CODE_BITS-1:0] adc_code,
    input  logic [TOT_W-1:0]     sample_total,
    input  logic [CODE_BITS-1:0] win_lo,
    input  logic [CODE_BITS-1:0] win_hi,
    input  logic [CNT_W-1:0]     floor_all,
    input  logic [CNT_W-1:0]     floor_win,
    output logic                 done,
    output logic                 pass,
    output logic [CODE_BITS-1:0] fail_idx,
    output logic [CNT_W-1:0]     fail_cnt,
    input  logic [CODE_BITS-1:0] rd_addr,
    output logic [CNT_W-1:0]     rd_data
);
    localparam logic [CODE_BITS-1:0] LAST_CODE = '1;
    localparam logic [CNT_W-1:0]     CNT_MAX   = '1;

    typedef struct packed {
        hist_state_e          state;
        logic [CODE_BITS-1:0] clr_idx;
        logic [TOT_W-1:0]     acc;
        logic [TOT_W-1:0]     total;
        logic [CODE_BITS-1:0] lo;
        logic [CODE_BITS-1:0] hi;
        logic [CNT_W-1:0]     fa;
        logic [CNT_W-1:0]     fw;
        logic                 p_vld;
        logic [CODE_BITS-1:0] p_code;
        logic                 lw_vld;
        logic [CODE_BITS-1:0] lw_code;
        logic [CNT_W-1:0]     lw_val;
        logic [CODE_BITS:0]   sidx;
        logic                 ev_vld;
        logic [CODE_BITS-1:0] ev_idx;
        logic                 pass;
        logic [CODE_BITS-1:0] fail_idx;
        logic [CNT_W-1:0]     fail_cnt;
    } regs_t;

    regs_t r_q, r_d;

    logic                 accept;
    logic                 cap_we;
    logic [CNT_W-1:0]     cap_base;
    logic [CNT_W-1:0]     cap_wdata;
    logic                 mem_we;
    logic [CODE_BITS-1:0] mem_waddr;
    logic [CNT_W-1:0]     mem_wdata;
    logic [CODE_BITS-1:0] ra_addr;
    logic [CNT_W-1:0]     ra_data;
    logic                 bin_fail;

    hist_mem #(
        .AW (CODE_BITS),
        .DW (CNT_W)
    ) i_mem (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .ra_addr (ra_addr),
        .ra_data (ra_data),
        .rb_addr (rd_addr),
        .rb_data (rd_data)
    );

    hist_bin_eval #(
        .CODE_BITS   (CODE_BITS),
        .CNT_W       (CNT_W),
        .EXEMPT_ENDS (EXEMPT_ENDS)
    ) i_eval (
        .idx  (r_q.ev_idx),
        .cnt  (ra_data),
        .lo   (r_q.lo),
        .hi   (r_q.hi),
        .fa   (r_q.fa),
        .fw   (r_q.fw),
        .fail (bin_fail)
    );

    // Capture datapath: stage 2 of the read-modify-write, with forwarding
    // of the value written one cycle earlier.
    always_comb begin
        accept   = (r_q.state == ST_CAPTURE) && adc_valid && (r_q.acc < r_q.total);
        cap_we   = r_q.p_vld;
        cap_base = (r_q.lw_vld && (r_q.lw_code == r_q.p_code)) ? r_q.lw_val : ra_data;
        cap_wdata = (cap_base == CNT_MAX) ? cap_base : cap_base + 1'b1;

        if (r_q.state == ST_CLEAR) begin
            mem_we    = 1'b1;
            mem_waddr = r_q.clr_idx;
            mem_wdata = '0;
        end else begin
            mem_we    = cap_we;
            mem_waddr = r_q.p_code;
            mem_wdata = cap_wdata;
        end

        ra_addr = (r_q.state == ST_SCAN) ? r_q.sidx[CODE_BITS-1:0] : adc_code;
    end

    // Next-state logic
    always_comb begin
        r_d        = r_q;
        r_d.p_vld  = accept;
        r_d.p_code = adc_code;
        r_d.ev_vld = 1'b0;

        if (accept) begin
            r_d.acc = r_q.acc + 1'b1;
        end
        if (cap_we) begin
            r_d.lw_vld  = 1'b1;
            r_d.lw_code = r_q.p_code;
            r_d.lw_val  = cap_wdata;
        end

        case (r_q.state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    r_d.state    = ST_CLEAR;
                    r_d.clr_idx  = '0;
                    r_d.acc      = '0;
                    r_d.total    = sample_total;
                    r_d.lo       = win_lo;
                    r_d.hi       = win_hi;
                    r_d.fa       = floor_all;
                    r_d.fw       = floor_win;
                    r_d.lw_vld   = 1'b0;
                    r_d.pass     = 1'b0;
                    r_d.fail_idx = '0;
                    r_d.fail_cnt = '0;
                end
            end
            ST_CLEAR: begin
                r_d.clr_idx = r_q.clr_idx + 1'b1;
                if (r_q.clr_idx == LAST_CODE) begin
                    r_d.state = ST_CAPTURE;
                end
            end
            ST_CAPTURE: begin
                if ((r_q.acc == r_q.total) && !r_q.p_vld) begin
                    r_d.state = ST_SCAN;
                    r_d.sidx  = '0;
                end
            end
            ST_SCAN: begin
                if (r_q.ev_vld && bin_fail) begin
                    r_d.state    = ST_DONE;
                    r_d.pass     = 1'b0;
                    r_d.fail_idx = r_q.ev_idx;
                    r_d.fail_cnt = ra_data;
                end else if (r_q.ev_vld && (r_q.ev_idx == LAST_CODE)) begin
                    r_d.state = ST_DONE;
                    r_d.pass  = 1'b1;
                end else if (!r_q.sidx[CODE_BITS]) begin
                    r_d.sidx   = r_q.sidx + 1'b1;
                    r_d.ev_vld = 1'b1;
                    r_d.ev_idx = r_q.sidx[CODE_BITS-1:0];
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign done     = (r_q.state == ST_DONE);
    assign pass     = r_q.pass;
    assign fail_idx = r_q.fail_idx;
    assign fail_cnt = r_q.fail_cnt;

endmodule

// File: rtl/hist_cov_checker.sv
module hist_cov_checker
    import hist_pkg::*;
#(
    parameter int CODE_BITS   = 12,
    parameter int CNT_W       = 17,
    parameter int TOT_W       = 17,
    parameter bit EXEMPT_ENDS = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 done,
    input logic                 pass,
    input logic [CODE_BITS-1:0] fail_idx,
    input logic [CNT_W-1:0]     fail_cnt,
    input hist_state_e          st,
    input logic                 cap_we,
    input logic [CNT_W-1:0]     cap_wdata,
    input logic [TOT_W-1:0]     acc,
    input logic [TOT_W-1:0]     total,
    input logic [CODE_BITS-1:0] lo,
    input logic [CODE_BITS-1:0] hi,
    input logic [CNT_W-1:0]     fa,
    input logic [CNT_W-1:0]     fw
);
    logic fail_in_win;
    assign fail_in_win = (fail_idx >= lo) && (fail_idx <= hi);

    p_done_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);

    p_done_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(start));

    p_pass_in_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);

    p_capture_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_we |-> st == ST_CAPTURE);

    p_count_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc <= total);

    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_we |-> cap_wdata != '0);

    p_win_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && !pass && fail_in_win |-> fail_cnt < fw);

    p_out_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && !pass && !fail_in_win |->
            (fail_cnt < fa) && (!EXEMPT_ENDS || ((fail_idx != '0) && (fail_idx != '1))));

endmodule

bind code_hist_cov hist_cov_checker #(
    .CODE_BITS   (CODE_BITS),
    .CNT_W       (CNT_W),
    .TOT_W       (TOT_W),
    .EXEMPT_ENDS (EXEMPT_ENDS)
) u_hist_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .pass      (pass),
    .fail_idx  (fail_idx),
    .fail_cnt  (fail_cnt),
    .st        (r_q.state),
    .cap_we    (cap_we),
    .cap_wdata (cap_wdata),
    .acc       (r_q.acc),
    .total     (r_q.total),
    .lo        (r_q.lo),
    .hi        (r_q.hi),
    .fa        (r_q.fa),
    .fw        (r_q.fw)
);

// File: tb/test_code_hist_cov.sv
`timescale 1ns/1ps
module test_code_hist_cov;
    localparam int CB    = 4;
    localparam int CW    = 4;
    localparam int TW    = 8;
    localparam int NB    = 1 << CB;
    localparam int SAT   = (1 << CW) - 1;
    localparam int EXTRA = 3;

    typedef struct packed {
        logic [1:0] pat;
        logic       gap;
        logic [7:0] total;
        logic [3:0] lo;
        logic [3:0] hi;
        logic [3:0] fa;
        logic [3:0] fw;
        logic       ep;
        logic [3:0] eidx;
        logic [3:0] ecnt;
    } vec_t;

    // pat 0: code i%16, pat 1: (i/4)%16, pat 2: code 8, pat 3: 0/15 alternating
    localparam vec_t VECS [11] = '{
        '{2'd0, 1'b0, 8'd48, 4'd6, 4'd9,  4'd3, 4'd3,  1'b1, 4'd0,  4'd0},
        '{2'd0, 1'b0, 8'd48, 4'd6, 4'd9,  4'd3, 4'd4,  1'b0, 4'd6,  4'd3},
        '{2'd0, 1'b0, 8'd47, 4'd4, 4'd5,  4'd3, 4'd3,  1'b1, 4'd0,  4'd0},
        '{2'd0, 1'b0, 8'd46, 4'd4, 4'd5,  4'd3, 4'd3,  1'b0, 4'd14, 4'd2},
        '{2'd1, 1'b0, 8'd64, 4'd0, 4'd15, 4'd4, 4'd4,  1'b1, 4'd0,  4'd0},
        '{2'd2, 1'b0, 8'd20, 4'd8, 4'd8,  4'd0, 4'd15, 1'b1, 4'd0,  4'd0},
        '{2'd2, 1'b0, 8'd20, 4'd7, 4'd8,  4'd0, 4'd1,  1'b0, 4'd7,  4'd0},
        '{2'd0, 1'b0, 8'd0,  4'd0, 4'd15, 4'd0, 4'd0,  1'b1, 4'd0,  4'd0},
        '{2'd0, 1'b0, 8'd48, 4'd0, 4'd2,  4'd0, 4'd4,  1'b0, 4'd0,  4'd3},
        '{2'd1, 1'b1, 8'd64, 4'd0, 4'd15, 4'd4, 4'd4,  1'b1, 4'd0,  4'd0},
        '{2'd3, 1'b0, 8'd10, 4'd7, 4'd7,  4'd1, 4'd0,  1'b0, 4'd1,  4'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          adc_valid = 1'b0;
    logic [CB-1:0] adc_code = '0;
    logic [TW-1:0] sample_total = '0;
    logic [CB-1:0] win_lo = '0;
    logic [CB-1:0] win_hi = '0;
    logic [CW-1:0] floor_all = '0;
    logic [CW-1:0] floor_win = '0;
    logic          done;
    logic          pass;
    logic [CB-1:0] fail_idx;
    logic [CW-1:0] fail_cnt;
    logic [CB-1:0] rd_addr = '0;
    logic [CW-1:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    int model [NB];

    always #4 clk = ~clk;

    code_hist_cov #(
        .CODE_BITS (CB),
        .CNT_W     (CW),
        .TOT_W     (TW)
    ) i_code_hist_cov (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .adc_valid    (adc_valid),
        .adc_code     (adc_code),
        .sample_total (sample_total),
        .win_lo       (win_lo),
        .win_hi       (win_hi),
        .floor_all    (floor_all),
        .floor_win    (floor_win),
        .done         (done),
        .pass         (pass),
        .fail_idx     (fail_idx),
        .fail_cnt     (fail_cnt),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int code_of(input int pat, input int i);
        case (pat)
            0:       return i % NB;
            1:       return (i / 4) % NB;
            2:       return 8;
            default: return (i % 2 == 1) ? NB - 1 : 0;
        endcase
    endfunction

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R11: start sampled one edge ago, done must now be low
        check("R11 done low after start", int'(done), 0);
    endtask

    task automatic wait_done();
        for (int k = 0; k < 3000; k++) begin
            if (done) return;
            @(negedge clk);
        end
        check("R9 scan completes", 0, 1);
    endtask

    task automatic read_bin(input int b, output int v);
        @(negedge clk);
        rd_addr = CB'(b);
        @(negedge clk);
        v = int'(rd_data);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 done", int'(done), 0);
        check("R1 pass", int'(pass), 0);
        check("R1 fail_idx", int'(fail_idx), 0);
        check("R1 fail_cnt", int'(fail_cnt), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int n = 0; n < 11; n++) begin
            vec_t t;
            t = VECS[n];
            sample_total = t.total;
            win_lo       = t.lo;
            win_hi       = t.hi;
            floor_all    = t.fa;
            floor_win    = t.fw;
            for (int b = 0; b < NB; b++) model[b] = 0;
            for (int i = 0; i < int'(t.total); i++) begin
                int c;
                c = code_of(int'(t.pat), i);
                if (model[c] < SAT) model[c]++;   // R6 saturation in the model
            end

            pulse_start();
            repeat (NB + 4) @(negedge clk);

            // R4: drive EXTRA strobes beyond the programmed total
            for (int i = 0; i < int'(t.total) + EXTRA; i++) begin
                adc_valid = 1'b1;
                adc_code  = CB'(code_of(int'(t.pat), i));
                @(negedge clk);
                if (t.gap) begin
                    adc_valid = 1'b0;
                    @(negedge clk);
                end
            end
            adc_valid = 1'b0;

            wait_done();
            check("R9/R10 pass", int'(pass), int'(t.ep));
            check("R9/R10 fail_idx", int'(fail_idx), int'(t.eidx));
            check("R9/R10 fail_cnt", int'(fail_cnt), int'(t.ecnt));

            // R2 R3 R4 R6 R12: every bin read back through the read port
            for (int b = 0; b < NB; b++) begin
                read_bin(b, v);
                check("R3 bin count", v, model[b]);
            end
        end

        // R5: strobes after done leave the histogram unchanged
        for (int i = 0; i < 5; i++) begin
            adc_valid = 1'b1;
            adc_code  = CB'(3);
            @(negedge clk);
        end
        adc_valid = 1'b0;
        read_bin(3, v);
        check("R5 bin untouched", v, 0);
        read_bin(0, v);
        check("R5 end bin untouched", v, 5);
        // R11: done held through idle cycles
        repeat (10) @(negedge clk);
        check("R11 done held", int'(done), 1);
        sample_total = '0;
        pulse_start();

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule